// File: doc/BRIEF.md
# Cycle-by-Cycle Current-Limited PWM Generator

This block produces a fixed-frequency pulse-width modulated drive for a power stage. A free-running count sweeps each period; the drive goes high at the start of every period and falls when the count reaches the programmed maximum duty. An external comparator watches the inductor current and feeds a trip level into the block. When that level goes high it cuts the pulse short within the current cycle, so the duty setting acts only as an upper limit on each pulse. This gives current-mode limiting without a faster clock or a finer count.

A second output resets an external ramp network for the first few clocks of every period, so that an analog ramp restarts in step with the drive. The period and duty settings are shadowed: new values are taken only at a period boundary, or continuously while the block is disabled. The PWM resolution is tied to the clock. A count of 2^N steps at a switching rate F needs a clock of 2^N times F.

Top module: `pwm_climit`

## Requirements
- R1: The internal count starts at 0 and advances by one per clock up to the active period value P, then returns to 0. A period therefore lasts P+1 clocks.
- R2: While enabled and not tripped, pwmOut is high on the counts 0 through D-1 of each period and low on the remaining counts, where D is the active duty value.
- R3: A duty value of 0 keeps pwmOut low on every count. A duty value greater than P keeps pwmOut high for the whole period unless a trip occurs.
- R4: While tripIn is high, pwmOut is low in that same clock cycle. The path from tripIn to pwmOut contains no register.
- R5: After tripIn has been seen high at a clock edge inside a period, pwmOut stays low for the rest of that period even if tripIn returns low. The pulse resumes at count 0 of the next period. A trip seen on the last count of a period does not carry into the next period.
- R6: periodIn and dutyIn are sampled only at the clock edge that ends a period (count equal to P), or at any edge while enable is low. A change at any other time has no effect until the next period begins.
- R7: rampRst is high while enabled and the count is below RAMP_CLKS (default 2). It is low for the rest of the period. If P+1 is not above RAMP_CLKS, rampRst stays high for the whole period.
- R8: While enable is low, pwmOut and rampRst are both low and the count is held at 0. The first enabled cycle is count 0 of a new period, using the inputs sampled while the block was disabled.
- R9: While rstN is low, the count, the shadowed period and the shadowed duty are all 0 and no trip is held. As a result, pwmOut is low during reset even with enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run control; low stops and clears the count |
| periodIn | input | CNT_W | Last count of a period (period = value + 1 clocks) |
| dutyIn | input | CNT_W | Maximum pulse length in clocks |
| tripIn | input | 1 | Digital level from the external current comparator; high ends the pulse |
| pwmOut | output | 1 | PWM drive |
| rampRst | output | 1 | Ramp reset pulse at each period start |

## Verification
The checker watches the following on every cycle: a high trip level forces the drive low, a trip inside a period holds the drive low on the next count, the count never passes the active period and wraps to 0 after it, the shadow registers stay put away from a boundary, and disabled operation is quiet. Some behaviours show only as whole-period sequences at the ports, and those are left to the bench scenarios. These are the exact number of high counts per period for each period and duty pair, the resumption of the pulse after a trip, the deferral of a mid-period duty change, and restart from count 0 after re-enable.

// File: rtl/pwm_climit_pkg.sv
package pwm_climit_pkg;

  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic holdZero;    // force count to zero (disabled)
    logic wrap;        // period ends this cycle, count returns to zero
    logic loadShadow;  // capture period/duty inputs at this edge
    logic clearTrip;   // drop the held trip at this edge
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_climit_dp.sv
module pwm_climit_dp
  import pwm_climit_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RAMP_CLKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] dutyIn,
  output logic             atEnd,
  output logic             belowDuty,
  output logic             inRampWin,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] periodQ,
  output logic [CNT_W-1:0] dutyQ
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cntNext;

  // Period counter
  always_comb begin
    if (strobe.holdZero || strobe.wrap) cntNext = ZERO;
    else                                cntNext = cntQ + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= ZERO;
    else       cntQ <= cntNext;
  end

  // Double-buffered settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= ZERO;
      dutyQ   <= ZERO;
    end else if (strobe.loadShadow) begin
      periodQ <= periodIn;
      dutyQ   <= dutyIn;
    end
  end

  // Magnitude comparators
  always_comb begin
    atEnd     = (cntQ == periodQ);
    belowDuty = (cntQ < dutyQ);
  end

  // Ramp window compare, variant picked by parameter
  generate
    if (RAMP_CLKS <= 0) begin : g_noRamp
      assign inRampWin = 1'b0;
    end else begin : g_ramp
      localparam logic [CNT_W:0] RAMP_LIM = (CNT_W+1)'(RAMP_CLKS);
      assign inRampWin = ({1'b0, cntQ} < RAMP_LIM);
    end
  endgenerate

endmodule

// File: rtl/pwm_climit_ctl.sv
module pwm_climit_ctl
  import pwm_climit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tripIn,
  input  logic       atEnd,
  input  logic       belowDuty,
  input  logic       inRampWin,
  output pwmStrobe_t strobe,
  output logic       pwmOut,
  output logic       rampRst
);

  logic tripHeld;

  always_comb begin
    strobe.holdZero   = !enable;
    strobe.wrap       = enable && atEnd;
    strobe.loadShadow = !enable || atEnd;
    strobe.clearTrip  = !enable || atEnd;
  end

  // Trip latch: set by any trip seen inside a period, cleared at boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tripHeld <= 1'b0;
    else if (strobe.clearTrip) tripHeld <= 1'b0;
    else if (tripIn)           tripHeld <= 1'b1;
  end

  // Output stage: duty compare sets the limit, trip cuts it at once
  always_comb begin
    pwmOut  = enable && belowDuty && !tripHeld && !tripIn;
    rampRst = enable && inRampWin;
  end

endmodule

// File: rtl/pwm_climit.sv
module pwm_climit
  import pwm_climit_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RAMP_CLKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic             tripIn,
  output logic             pwmOut,
  output logic             rampRst
);

  pwmStrobe_t       strobe;
  logic             atEnd;
  logic             belowDuty;
  logic             inRampWin;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] periodQ;
  logic [CNT_W-1:0] dutyQ;

  pwm_climit_dp #(.CNT_W(CNT_W), .RAMP_CLKS(RAMP_CLKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .periodIn  (periodIn),
    .dutyIn    (dutyIn),
    .atEnd     (atEnd),
    .belowDuty (belowDuty),
    .inRampWin (inRampWin),
    .cntQ      (cntQ),
    .periodQ   (periodQ),
    .dutyQ     (dutyQ)
  );

  pwm_climit_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .tripIn    (tripIn),
    .atEnd     (atEnd),
    .belowDuty (belowDuty),
    .inRampWin (inRampWin),
    .strobe    (strobe),
    .pwmOut    (pwmOut),
    .rampRst   (rampRst)
  );

endmodule

// File: rtl/pwm_climit_chk.sv
module pwm_climit_chk #(
  parameter int CNT_W     = 8,
  parameter int RAMP_CLKS = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             tripIn,
  input logic             pwmOut,
  input logic             rampRst,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] periodQ,
  input logic [CNT_W-1:0] dutyQ
);

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= periodQ);

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cntQ == periodQ) |=> (cntQ == '0));

  a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rstN)
    (dutyQ == '0) |-> !pwmOut);

  a_r4_trip_kills: assert property (@(posedge clk) disable iff (!rstN)
    tripIn |-> !pwmOut);

  a_r5_trip_holds: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tripIn && cntQ != periodQ) |=> !pwmOut);

  a_r6_shadow_stable: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cntQ != periodQ) |=> ($stable(periodQ) && $stable(dutyQ)));

  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!pwmOut && !rampRst));

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (cntQ == '0));

  generate
    if (RAMP_CLKS > 0) begin : g_rampChk
      a_r7_ramp_at_start: assert property (@(posedge clk) disable iff (!rstN)
        (enable && cntQ == '0) |-> rampRst);
    end
  endgenerate

endmodule

bind pwm_climit pwm_climit_chk #(.CNT_W(CNT_W), .RAMP_CLKS(RAMP_CLKS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .tripIn  (tripIn),
  .pwmOut  (pwmOut),
  .rampRst (rampRst),
  .cntQ    (cntQ),
  .periodQ (periodQ),
  .dutyQ   (dutyQ)
);

// File: tb/pwm_climit_test.sv
module pwm_climit_test;

  localparam int W    = 8;
  localparam int RAMP = 2;
  localparam int NONE = 255;
  localparam int NV   = 8;
  // {period, duty, trip count (255 = none)}
  localparam logic [23:0] VEC [NV] = '{
    {8'd7, 8'd3, 8'd255},   // R2 basic
    {8'd7, 8'd0, 8'd255},   // R3 zero duty
    {8'd5, 8'd9, 8'd255},   // R3 duty above period
    {8'd9, 8'd6, 8'd2},     // R4 R5 mid-pulse trip
    {8'd9, 8'd9, 8'd255},   // R2 duty equal period
    {8'd3, 8'd2, 8'd0},     // R4 trip at count 0
    {8'd1, 8'd1, 8'd255},   // R7 short period
    {8'd6, 8'd4, 8'd6}      // R5 trip on last count
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] periodIn = '0;
  logic [W-1:0] dutyIn = '0;
  logic tripIn = 1'b0;
  logic pwmOut, rampRst;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwm_climit #(.CNT_W(W), .RAMP_CLKS(RAMP)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .periodIn(periodIn),
    .dutyIn(dutyIn), .tripIn(tripIn), .pwmOut(pwmOut), .rampRst(rampRst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Called at a negedge with the count at 0; runs one period and checks it
  task automatic runPeriod(input string req, input int p, input int d,
                           input int tripAt);
    bit tripped = 0;
    for (int k = 0; k <= p; k++) begin
      tripIn = (k == tripAt);
      if (k == tripAt) tripped = 1;
      #1;
      check({req, " pwm"}, pwmOut, (k < d) && !tripped);
      check("R7 ramp", rampRst, k < RAMP);
      @(negedge clk);
    end
    tripIn = 1'b0;
  endtask

  task automatic startWith(input int p, input int d);
    enable = 1'b0;
    periodIn = W'(p);
    dutyIn = W'(d);
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    // R9 reset state
    enable = 1'b1; periodIn = 8'd5; dutyIn = 8'd3;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset pwm low", pwmOut, 1'b0);
    enable = 1'b0;
    #1;
    check("R8 disabled ramp", rampRst, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      int p, d, t;
      p = int'(VEC[i][23:16]);
      d = int'(VEC[i][15:8]);
      t = int'(VEC[i][7:0]);
      startWith(p, d);
      runPeriod("R2", p, d, t);
      runPeriod("R5 resume", p, d, NONE);
    end

    // R6: duty change mid-period waits for boundary
    startWith(7, 2);
    for (int k = 0; k <= 7; k++) begin
      if (k == 3) begin dutyIn = 8'd6; periodIn = 8'd4; end
      #1;
      check("R6 old duty", pwmOut, k < 2);
      @(negedge clk);
    end
    runPeriod("R6 new duty", 4, 6, NONE);

    // R5: trip then release, stays low to end of period
    startWith(8, 8);
    for (int k = 0; k <= 8; k++) begin
      tripIn = (k == 1);
      #1;
      check("R5 latched", pwmOut, k < 1);
      @(negedge clk);
    end
    tripIn = 1'b0;
    runPeriod("R5 next", 8, 8, NONE);

    // R8: disable mid-period, restart from count 0
    startWith(7, 5);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    #1;
    check("R8 disable pwm", pwmOut, 1'b0);
    check("R8 disable ramp", rampRst, 1'b0);
    dutyIn = 8'd3;
    @(negedge clk);
    enable = 1'b1;
    runPeriod("R8 restart", 7, 3, NONE);
    // R1: period length check continues seamlessly
    runPeriod("R1 wrap", 7, 3, NONE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1;
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule